// File: doc/BRIEF.md
# Dual-Channel Video Line CRC Checker

This block sits after the word framer in a high-definition serial video receiver. It takes framed 10-bit chroma and luma words together with a marker that is high for the four words of every timing reference sequence. For each channel it keeps a running checksum over the line. It picks up the line number carried just after the end-of-active-video reference. It then compares its own checksum against the two checksum words the transmitter placed after the line number. The result is one 11-bit line number and one error flag per channel.

The two channels run through identical, independent engines that share one word-position sequencer. The sequencer classifies every word from the marker and from bit 6 of the luma reference word. A clock enable qualifies every word. An asynchronous active-low reset is released in step with the clock.

Top module: `dual_line_crc_chk`

## Requirements
- R1: After reset, both line-number outputs and both error flags are 0.
- R2: Line number: bits 6:0 come from bits 8:2 of the first word after the end-of-active-video reference word, and bits 10:7 come from bits 5:2 of the second word after it.
- R3: Checksum: 18-bit Galois register with polynomial x^18 + x^5 + x^4 + 1 (feedback mask 0x00031). Each word is fed LSB first, with feedback = reg[17] ^ data bit and the register shifting towards its MSB. The register is cleared by the start-of-active-video reference word and covers every later non-marker word up to and including the second line-number word.
- R4: Reference words (marker high) are excluded from the checksum. So are words outside the active region: those after the checksum words and those before the first start-of-active-video reference.
- R5: Received checksum: bits 8:0 of the third word after the end reference hold checksum bits 8:0, and bits 8:0 of the fourth word hold bits 17:9. A mismatch with the computed value sets that channel's error flag.
- R6: The chroma and luma channels are checked independently, and an error on one leaves the other's flag and line number untouched.
- R7: Bit 9 of each checksum word must be the inverse of its bit 8. A violation in either word sets the error flag even when the checksum matches.
- R8: The error flag is updated only on the clock edge that takes the fourth word after the end reference. Between comparisons it holds its value, so two bad lines in a row give one level, not two pulses.
- R9: On an edge with the clock enable low, nothing changes and the words and marker present are ignored.
- R10: A reference word is the fourth consecutive enabled word with the marker high. Bit 6 of the luma word there selects end of active video (1) or start of active video (0).
- R11: The line-number outputs change only on the edge that takes the second line-number word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Word-valid clock enable |
| c_word | input | 10 | Framed chroma word |
| y_word | input | 10 | Framed luma word |
| trs | input | 1 | High during the four words of a timing reference |
| c_ln | output | 11 | Captured chroma line number |
| y_ln | output | 11 | Captured luma line number |
| c_crc_err | output | 1 | Chroma checksum error flag |
| y_crc_err | output | 1 | Luma checksum error flag |

## Verification
The bench builds the block with its default parameters. These are the 10-bit word, the 11-bit line number, the 18-bit checksum with its fixed polynomial, and a two-stage reset synchronizer, so every line layout the format allows is reachable. Those values bring the all-ones line number, checksum corruption in either half, and the bit-9 inversion rule within reach. With them the bench can also drive disabled cycles that carry marker pulses and junk words into the middle of a line.

// File: rtl/lcrc_pkg.sv
`timescale 1ns/1ps
package lcrc_pkg;
  localparam int WORD_W   = 10;
  localparam int LN_W     = 11;
  localparam int CRC_W    = 18;
  localparam logic [CRC_W-1:0] CRC_POLY = 18'h00031;
  localparam int XYZ_H_BIT = 6;

  typedef enum logic [2:0] {
    POS_IDLE, POS_LN0, POS_LN1, POS_CRC0, POS_CRC1
  } pos_t;

  // Word classification for the word currently on the inputs
  typedef struct packed {
    logic sav_xyz;
    logic eav_xyz;
    logic ln0;
    logic ln1;
    logic crc0;
    logic crc1;
    logic accum;
  } slot_t;
endpackage

// File: rtl/lcrc_rst_sync.sv
`timescale 1ns/1ps
module lcrc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_q = sh_q[STAGES-1];
endmodule

// File: rtl/lcrc_seq.sv
`timescale 1ns/1ps
module lcrc_seq
  import lcrc_pkg::*;
#(
  parameter int W     = WORD_W,
  parameter int H_BIT = XYZ_H_BIT
) (
  input  logic         clk,
  input  logic         rst_q,
  input  logic         ce,
  input  logic         trs,
  input  logic [W-1:0] y_word,
  output slot_t        slot
);
  logic [1:0] cnt_q, cnt_n;
  pos_t       pos_q, pos_n;
  logic       act_q, act_n;
  logic       xyz;

  // current-word decode
  always_comb begin
    xyz          = trs && (cnt_q == 2'd3);
    slot.sav_xyz = xyz && !y_word[H_BIT];
    slot.eav_xyz = xyz &&  y_word[H_BIT];
    slot.ln0     = (pos_q == POS_LN0);
    slot.ln1     = (pos_q == POS_LN1);
    slot.crc0    = (pos_q == POS_CRC0);
    slot.crc1    = (pos_q == POS_CRC1);
    slot.accum   = (act_q && !trs) || slot.ln0 || slot.ln1;
  end

  // next state
  always_comb begin
    cnt_n = cnt_q;
    pos_n = pos_q;
    act_n = act_q;
    if (ce) begin
      cnt_n = trs ? cnt_q + 2'd1 : 2'd0;
      if (slot.sav_xyz) act_n = 1'b1;
      if (slot.eav_xyz) begin
        act_n = 1'b0;
        pos_n = POS_LN0;
      end else begin
        unique case (pos_q)
          POS_LN0:  pos_n = POS_LN1;
          POS_LN1:  pos_n = POS_CRC0;
          POS_CRC0: pos_n = POS_CRC1;
          POS_CRC1: pos_n = POS_IDLE;
          default:  pos_n = POS_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      cnt_q <= 2'd0;
      pos_q <= POS_IDLE;
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      pos_q <= pos_n;
      act_q <= act_n;
    end
  end
endmodule

// File: rtl/lcrc_chan.sv
`timescale 1ns/1ps
module lcrc_chan
  import lcrc_pkg::*;
#(
  parameter int W    = WORD_W,
  parameter int LNW  = LN_W,
  parameter int CW   = CRC_W,
  parameter logic [CW-1:0] POLY = CRC_POLY
) (
  input  logic           clk,
  input  logic           rst_q,
  input  logic           ce,
  input  logic [W-1:0]   word,
  input  slot_t          slot,
  output logic [LNW-1:0] ln,
  output logic           err,
  output logic [CW-1:0]  crc_run
);
  localparam int LO_W = 7;
  localparam int HI_W = LNW - LO_W;
  localparam int HALF = CW / 2;

  logic [CW-1:0]   crc_q, crc_n, crc_upd;
  logic [LO_W-1:0] ln_lo_q, ln_lo_n;
  logic [LNW-1:0]  ln_q, ln_n;
  logic [HALF-1:0] rx_lo_q, rx_lo_n;
  logic            lo_bad_q, lo_bad_n;
  logic            err_q, err_n;

  // one word through the LFSR, LSB first
  always_comb begin
    logic fb;
    crc_upd = crc_q;
    for (int i = 0; i < W; i++) begin
      fb      = crc_upd[CW-1] ^ word[i];
      crc_upd = {crc_upd[CW-2:0], 1'b0};
      if (fb) crc_upd = crc_upd ^ POLY;
    end
  end

  always_comb begin
    crc_n    = crc_q;
    ln_lo_n  = ln_lo_q;
    ln_n     = ln_q;
    rx_lo_n  = rx_lo_q;
    lo_bad_n = lo_bad_q;
    err_n    = err_q;
    if (ce) begin
      if (slot.sav_xyz)    crc_n = '0;
      else if (slot.accum) crc_n = crc_upd;
      if (slot.ln0) ln_lo_n = word[LO_W+1:2];
      if (slot.ln1) ln_n    = {word[HI_W+1:2], ln_lo_q};
      if (slot.crc0) begin
        rx_lo_n  = word[HALF-1:0];
        lo_bad_n = (word[HALF] == word[HALF-1]);
      end
      if (slot.crc1)
        err_n = lo_bad_q || (word[HALF] == word[HALF-1]) ||
                (crc_q != {word[HALF-1:0], rx_lo_q});
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      crc_q    <= '0;
      ln_lo_q  <= '0;
      ln_q     <= '0;
      rx_lo_q  <= '0;
      lo_bad_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      crc_q    <= crc_n;
      ln_lo_q  <= ln_lo_n;
      ln_q     <= ln_n;
      rx_lo_q  <= rx_lo_n;
      lo_bad_q <= lo_bad_n;
      err_q    <= err_n;
    end
  end

  assign ln      = ln_q;
  assign err     = err_q;
  assign crc_run = crc_q;
endmodule

// File: rtl/dual_line_crc_chk.sv
`timescale 1ns/1ps
module dual_line_crc_chk
  import lcrc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic [WORD_W-1:0] c_word,
  input  logic [WORD_W-1:0] y_word,
  input  logic              trs,
  output logic [LN_W-1:0]   c_ln,
  output logic [LN_W-1:0]   y_ln,
  output logic              c_crc_err,
  output logic              y_crc_err
);
  localparam int CH_N = 2;   // 0 = chroma, 1 = luma

  logic                rst_q;
  slot_t               slot;
  logic [WORD_W-1:0]   words   [CH_N];
  logic [LN_W-1:0]     ln_arr  [CH_N];
  logic                err_arr [CH_N];
  logic [CRC_W-1:0]    crc_arr [CH_N];
  logic [CRC_W-1:0]    crc_c, crc_y;

  lcrc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q(rst_q)
  );

  lcrc_seq u_seq (
    .clk(clk), .rst_q(rst_q), .ce(ce), .trs(trs), .y_word(y_word), .slot(slot)
  );

  assign words[0] = c_word;
  assign words[1] = y_word;

  for (genvar gi = 0; gi < CH_N; gi++) begin : g_ch
    lcrc_chan u_ch (
      .clk(clk), .rst_q(rst_q), .ce(ce), .word(words[gi]), .slot(slot),
      .ln(ln_arr[gi]), .err(err_arr[gi]), .crc_run(crc_arr[gi])
    );
  end

  assign c_ln      = ln_arr[0];
  assign y_ln      = ln_arr[1];
  assign c_crc_err = err_arr[0];
  assign y_crc_err = err_arr[1];
  assign crc_c     = crc_arr[0];
  assign crc_y     = crc_arr[1];
endmodule

// File: rtl/lcrc_chk.sv
`timescale 1ns/1ps
module lcrc_chk
  import lcrc_pkg::*;
(
  input logic             clk,
  input logic             rst_q,
  input logic             ce,
  input logic             s_sav,
  input logic             s_eav,
  input logic             s_ln0,
  input logic             s_ln1,
  input logic             s_crc1,
  input logic [LN_W-1:0]  c_ln,
  input logic [LN_W-1:0]  y_ln,
  input logic             c_err,
  input logic             y_err,
  input logic [CRC_W-1:0] crc_c,
  input logic [CRC_W-1:0] crc_y
);
  // error flags move only after a second checksum word (R8)
  p_err_hold_r8: assert property (@(posedge clk) disable iff (!rst_q)
    (!$stable(c_err) || !$stable(y_err)) |-> $past(s_crc1 && ce));

  // line numbers move only after the second line-number word (R11)
  p_ln_hold_r11: assert property (@(posedge clk) disable iff (!rst_q)
    (!$stable(c_ln) || !$stable(y_ln)) |-> $past(s_ln1 && ce));

  // disabled edge freezes every output and running checksum (R9)
  p_ce_freeze_r9: assert property (@(posedge clk) disable iff (!rst_q)
    !$past(ce) |-> ($stable(c_ln) && $stable(y_ln) && $stable(c_err) &&
                    $stable(y_err) && $stable(crc_c) && $stable(crc_y)));

  // start reference clears both checksum registers (R3)
  p_sav_clear_r3: assert property (@(posedge clk) disable iff (!rst_q)
    (ce && s_sav) |=> (crc_c == '0 && crc_y == '0));

  // end reference is followed by the first line-number slot (R10)
  p_eav_to_ln_r10: assert property (@(posedge clk) disable iff (!rst_q)
    (ce && s_eav) |=> s_ln0);
endmodule

bind dual_line_crc_chk lcrc_chk u_chk (
  .clk(clk), .rst_q(rst_q), .ce(ce),
  .s_sav(slot.sav_xyz), .s_eav(slot.eav_xyz), .s_ln0(slot.ln0),
  .s_ln1(slot.ln1), .s_crc1(slot.crc1),
  .c_ln(c_ln), .y_ln(y_ln), .c_err(c_crc_err), .y_err(y_crc_err),
  .crc_c(crc_c), .crc_y(crc_y)
);

// File: tb/dual_line_crc_chk_tb_top.sv
`timescale 1ns/1ps
module dual_line_crc_chk_tb_top;
  logic       clk = 1'b0;
  logic       rst_n, ce, trs;
  logic [9:0] c_word, y_word;
  logic [10:0] c_ln, y_ln;
  logic       c_crc_err, y_crc_err;

  int n_run = 0, n_fail = 0;
  bit gaps = 0;
  logic [10:0] prev_c_ln, prev_y_ln;

  always #2.5 clk = ~clk;

  dual_line_crc_chk dut_i (
    .clk(clk), .rst_n(rst_n), .ce(ce), .c_word(c_word), .y_word(y_word),
    .trs(trs), .c_ln(c_ln), .y_ln(y_ln), .c_crc_err(c_crc_err),
    .y_crc_err(y_crc_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // checksum model from R3: shift toward MSB, fold in mask on feedback
  function automatic logic [17:0] mcrc(input logic [17:0] c, input logic [9:0] w);
    logic [17:0] r = c;
    for (int b = 0; b < 10; b++) begin
      logic top = r[17];
      r = r << 1;
      if (top ^ w[b]) begin r[0] = ~r[0]; r[4] = ~r[4]; r[5] = ~r[5]; end
    end
    return r;
  endfunction

  function automatic logic [9:0] pat(input int seed, input int i);
    return 10'((seed * 37 + i * 113 + i * i * 7) & 32'h3FF);
  endfunction

  task automatic send(input logic [9:0] cw, input logic [9:0] yw, input logic t);
    if (gaps) begin
      @(negedge clk);
      ce = 1'b0; c_word = ~cw; y_word = 10'h3FF; trs = 1'b1;
    end
    @(negedge clk);
    ce = 1'b1; c_word = cw; y_word = yw; trs = t;
  endtask

  task automatic send_line(input int n, input int cs, input int ys,
                           input logic [10:0] cl, input logic [10:0] yl,
                           input logic [17:0] cflip, input logic [17:0] yflip,
                           input bit cpar, input bit ypar, input int pre);
    logic [17:0] cc = '0, yc = '0;
    logic [9:0] cw, yw;
    for (int i = 0; i < pre; i++) send(pat(cs + 5, i), pat(ys + 9, i), 1'b0);
    send(10'h3FF, 10'h3FF, 1'b1); send(10'h000, 10'h000, 1'b1);
    send(10'h000, 10'h000, 1'b1); send(10'h200, 10'h200, 1'b1);
    for (int i = 0; i < n; i++) begin
      cw = pat(cs, i); yw = pat(ys, i);
      cc = mcrc(cc, cw); yc = mcrc(yc, yw);
      send(cw, yw, 1'b0);
    end
    send(10'h3FF, 10'h3FF, 1'b1); send(10'h000, 10'h000, 1'b1);
    send(10'h000, 10'h000, 1'b1); send(10'h274, 10'h274, 1'b1);
    cw = {~cl[6], cl[6:0], 2'b00}; yw = {~yl[6], yl[6:0], 2'b00};
    cc = mcrc(cc, cw); yc = mcrc(yc, yw);
    send(cw, yw, 1'b0);
    cw = {4'b1000, cl[10:7], 2'b00}; yw = {4'b1000, yl[10:7], 2'b00};
    cc = mcrc(cc, cw); yc = mcrc(yc, yw);
    send(cw, yw, 1'b0);
    // R11: LN outputs still old while second LN word is on the inputs
    chk("R11 c_ln before update", c_ln, prev_c_ln);
    chk("R11 y_ln before update", y_ln, prev_y_ln);
    cc = cc ^ cflip; yc = yc ^ yflip;
    send({cpar ? cc[8] : ~cc[8], cc[8:0]}, {ypar ? yc[8] : ~yc[8], yc[8:0]}, 1'b0);
    send({~cc[17], cc[17:9]}, {~yc[17], yc[17:9]}, 1'b0);
    send(10'h2AA, 10'h155, 1'b0);
    prev_c_ln = cl; prev_y_ln = yl;
  endtask

  task automatic expect_out(input string tag, input int cl, input int yl,
                            input int ce_, input int ye_);
    chk({tag, " c_ln"}, c_ln, cl);
    chk({tag, " y_ln"}, y_ln, yl);
    chk({tag, " c_crc_err"}, c_crc_err, ce_);
    chk({tag, " y_crc_err"}, y_crc_err, ye_);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ce = 1'b0; trs = 1'b0; c_word = '0; y_word = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    expect_out("R1 reset", 0, 0, 0, 0);
    prev_c_ln = '0; prev_y_ln = '0;
  endtask

  task automatic t_good();
    send_line(16, 3, 11, 11'd5, 11'd5, '0, '0, 0, 0, 0);
    expect_out("R2 R3 R5 R10 good line", 5, 5, 0, 0);
  endtask

  task automatic t_luma_bad();
    send_line(20, 7, 13, 11'd6, 11'd6, '0, 18'h00001, 0, 0, 2);
    expect_out("R5 R6 luma bad", 6, 6, 0, 1);
    repeat (6) send(10'h3FF, 10'h000, 1'b0);
    chk("R8 luma err held in blanking", y_crc_err, 1);
  endtask

  task automatic t_chroma_bad();
    send_line(9, 21, 2, 11'd7, 11'd7, 18'h20000, '0, 0, 0, 1);
    expect_out("R5 R6 R8 chroma bad, luma clears", 7, 7, 1, 0);
  endtask

  task automatic t_recover();
    send_line(12, 4, 8, 11'd8, 11'd8, '0, '0, 0, 0, 0);
    expect_out("R8 recover", 8, 8, 0, 0);
  endtask

  task automatic t_parity();
    send_line(10, 30, 31, 11'd9, 11'd9, '0, '0, 1, 0, 0);
    expect_out("R7 chroma bit9 rule", 9, 9, 1, 0);
  endtask

  task automatic t_ln_edges();
    send_line(14, 40, 41, 11'h7FF, 11'h465, '0, '0, 0, 0, 0);
    expect_out("R2 R6 LN extremes", 11'h7FF, 11'h465, 0, 0);
  endtask

  task automatic t_gaps();
    gaps = 1;
    send_line(11, 50, 51, 11'd300, 11'd301, '0, 18'h10000, 0, 0, 3);
    expect_out("R9 disabled gaps", 300, 301, 0, 1);
    gaps = 0;
  endtask

  task automatic t_exclude();
    send_line(18, 60, 61, 11'd12, 11'd12, '0, '0, 0, 0, 25);
    expect_out("R4 outside words excluded", 12, 12, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_good();
    t_luma_bad();
    t_chroma_bad();
    t_recover();
    t_parity();
    t_ln_edges();
    t_gaps();
    t_exclude();
    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule